// File: doc/BRIEF.md
# Hashed MAC Address Lookup Engine

This engine resolves a 48-bit Ethernet destination address to an egress port for a learning switch. A CRC-16 of the address picks one of a fixed number of buckets. Each bucket holds a head pointer into an on-chip entry array, and the entries that share a bucket are linked by next-pointers. A lookup follows that chain one entry per clock cycle. It stops at the first entry whose stored address equals the search key, or at the null pointer that ends the chain.

Requests use a valid/ready handshake. The engine takes one lookup at a time and returns a one-cycle result pulse that carries a hit flag and the stored port. Software or a learning agent fills the table through a separate write port. The write port names a free entry index and pushes that entry onto the front of its bucket's chain. Freeing entries, aging them out, and choosing which index to use all belong to the agent and are outside this block.

Top module: `mac_hash_lookup`

## Requirements
- R1: The bucket of a key is the low log2(BUCKETS) bits of a CRC-16 over the 48-bit key. The CRC uses generator 0x8005, starts from an all-zero register, and shifts the key in starting at bit 47. Keys with equal bucket values share one chain.
- R2: After reset, `req_ready` is 1, `res_valid` is 0, and every bucket is empty, so any lookup misses.
- R3: An accepted write makes its entry the first entry of its bucket's chain. The previous chain follows behind it.
- R4: A lookup that finds its key reports `res_hit`=1 and `res_port` equal to the port stored with that key.
- R5: A lookup that reaches the end of its chain without a match reports `res_hit`=0 and `res_port`=0.
- R6: Say the request is accepted on edge k. A match at chain position h (first entry is h=1) raises `res_valid` from edge k+h. A miss on a chain of L entries raises it from edge k+L+1.
- R7: `res_valid` is high for exactly one cycle. `req_ready` is low from the edge that accepts a request until the edge after the result cycle, and then returns high.
- R8: `wr_ack` is 0 and the write has no effect while `req_ready` is low, that is, while a lookup is in progress.
- R9: Index 0 is the null pointer. A write to index 0 is refused (`wr_ack`=0) and has no effect.
- R10: If the same key is written twice, lookups return the port of the most recent write.
- R11: A lookup accepted on the same edge as a write sees the table as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Engine idle; a request is accepted when valid and ready are both high |
| req_key | input | 48 | Destination MAC address to search |
| res_valid | output | 1 | One-cycle result strobe |
| res_hit | output | 1 | Key found |
| res_port | output | 4 | Port of the matching entry, 0 on a miss |
| wr_en | input | 1 | Insert request |
| wr_ack | output | 1 | Insert taken on this edge |
| wr_idx | input | 5 | Entry index to fill (must be nonzero and free) |
| wr_key | input | 48 | MAC address to store |
| wr_port | input | 4 | Port to store |

## Verification
A lookup's result is due exactly h edges after the accepting edge on a hit at chain position h, and L+1 edges after it on a miss over L entries. The bench keeps a reference model of the chains, computes the expected edge count from that model, and counts rising edges from acceptance to the first falling-edge sample where `res_valid` is high. It then compares that count with the model's value. `wr_ack` is combinational and is sampled one time unit after the stimulus is driven, in the same low phase. The cycle after each result is also sampled, to confirm that the strobe has dropped and `req_ready` has returned.

// File: rtl/mac_hash_pkg.sv
package mac_hash_pkg;
  localparam int          MAC_W    = 48;
  localparam int          EGRESS_W = 4;
  localparam logic [15:0] CRC_GEN  = 16'h8005;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_DONE = 2'd2
  } walk_state_e;
endpackage

// File: rtl/mac_crc16_hash.sv
module mac_crc16_hash
  import mac_hash_pkg::*;
#(
  parameter int KEY_W = MAC_W,
  parameter int BKT_W = 4
) (
  input  logic [KEY_W-1:0] key,
  output logic [BKT_W-1:0] bucket
);
  logic [15:0] crc;

  // Serial CRC unrolled: one shift/xor step per key bit, MSB first.
  always_comb begin
    logic fb;
    crc = 16'h0000;
    for (int i = KEY_W - 1; i >= 0; i--) begin
      fb  = crc[15] ^ key[i];
      crc = {crc[14:0], 1'b0} ^ (fb ? CRC_GEN : 16'h0000);
    end
  end

  assign bucket = crc[BKT_W-1:0];
endmodule

// File: rtl/mac_entry_store.sv
module mac_entry_store
  import mac_hash_pkg::*;
#(
  parameter int KEY_W   = MAC_W,
  parameter int PORT_W  = EGRESS_W,
  parameter int BUCKETS = 16,
  parameter int ENTRIES = 32,
  localparam int BKT_W  = $clog2(BUCKETS),
  localparam int PTR_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  // bucket head read
  input  logic [BKT_W-1:0]  head_rd_bkt,
  output logic [PTR_W-1:0]  head_rd_ptr,
  // entry read
  input  logic [PTR_W-1:0]  ent_rd_ptr,
  output logic              ent_rd_valid,
  output logic [KEY_W-1:0]  ent_rd_key,
  output logic [PORT_W-1:0] ent_rd_port,
  output logic [PTR_W-1:0]  ent_rd_next,
  // head insertion
  input  logic              wr_strobe,
  input  logic [BKT_W-1:0]  wr_bkt,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic [KEY_W-1:0]  wr_key,
  input  logic [PORT_W-1:0] wr_port
);
  logic [PTR_W-1:0]  head_q   [BUCKETS];
  logic [ENTRIES-1:0] vld_q;
  logic [KEY_W-1:0]  key_mem  [ENTRIES];
  logic [PORT_W-1:0] port_mem [ENTRIES];
  logic [PTR_W-1:0]  next_mem [ENTRIES];
  logic [PTR_W-1:0]  old_head;

  assign old_head = head_q[wr_bkt];

  // Bucket heads and valid flags: reset to empty.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < BUCKETS; b++) head_q[b] <= '0;
      vld_q <= '0;
    end else if (wr_strobe) begin
      head_q[wr_bkt] <= wr_idx;
      vld_q[wr_idx]  <= 1'b1;
    end
  end

  // Entry payload: no reset, only reachable through a head pointer.
  always_ff @(posedge clk) begin
    if (wr_strobe) begin
      key_mem[wr_idx]  <= wr_key;
      port_mem[wr_idx] <= wr_port;
      next_mem[wr_idx] <= old_head;
    end
  end

  assign head_rd_ptr  = head_q[head_rd_bkt];
  assign ent_rd_valid = vld_q[ent_rd_ptr];
  assign ent_rd_key   = key_mem[ent_rd_ptr];
  assign ent_rd_port  = port_mem[ent_rd_ptr];
  assign ent_rd_next  = next_mem[ent_rd_ptr];

  // R9: the null slot is never filled
  assert_no_null_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> (wr_idx != '0));

  // R3: after an insert the bucket head names the new entry
  assert_head_insert_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && !$isunknown(wr_bkt)) |=> (head_q[$past(wr_bkt)] == $past(wr_idx)));
endmodule

// File: rtl/mac_walk_ctrl.sv
module mac_walk_ctrl
  import mac_hash_pkg::*;
#(
  parameter int KEY_W  = MAC_W,
  parameter int PORT_W = EGRESS_W,
  parameter int PTR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [KEY_W-1:0]  req_key,
  input  logic [PTR_W-1:0]  head_ptr,
  output logic [PTR_W-1:0]  ent_ptr,
  input  logic              ent_valid,
  input  logic [KEY_W-1:0]  ent_key,
  input  logic [PORT_W-1:0] ent_port,
  input  logic [PTR_W-1:0]  ent_next,
  output logic              res_valid,
  output logic              res_hit,
  output logic [PORT_W-1:0] res_port,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_idx,
  output logic              wr_ack
);
  walk_state_e       state_q, state_d;
  logic [KEY_W-1:0]  key_q, key_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic              hit_q, hit_d;
  logic [PORT_W-1:0] port_q, port_d;
  logic              ld_en;
  logic              is_idle;

  assign is_idle = (state_q == ST_IDLE);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    key_d   = key_q;
    ptr_d   = ptr_q;
    hit_d   = hit_q;
    port_d  = port_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          key_d   = req_key;
          ptr_d   = head_ptr;
          state_d = ST_WALK;
        end
      end
      ST_WALK: begin
        if (ptr_q == '0) begin
          hit_d   = 1'b0;
          port_d  = '0;
          state_d = ST_DONE;
        end else if (ent_valid && (ent_key == key_q)) begin
          hit_d   = 1'b1;
          port_d  = ent_port;
          state_d = ST_DONE;
        end else begin
          ptr_d = ent_next;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign ld_en = (is_idle && req_valid) || (state_q == ST_WALK);

  // Control and result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hit_q   <= 1'b0;
      port_q  <= '0;
    end else begin
      state_q <= state_d;
      hit_q   <= hit_d;
      port_q  <= port_d;
    end
  end

  // Datapath registers with explicit enable
  always_ff @(posedge clk) begin
    if (ld_en) begin
      key_q <= key_d;
      ptr_q <= ptr_d;
    end
  end

  assign req_ready = is_idle;
  assign ent_ptr   = ptr_q;
  assign res_valid = (state_q == ST_DONE);
  assign res_hit   = hit_q;
  assign res_port  = port_q;
  assign wr_ack    = wr_en && is_idle && (wr_idx != '0);

  // R7: the result strobe lasts one cycle
  assert_result_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R7: an accepted request makes the engine busy
  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R7: ready returns right after the result cycle
  assert_ready_after_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> req_ready);

  // R5: a miss carries a zero port
  assert_miss_port_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_port == '0));

  // R4: a hit is only reported for a walk that reached a nonzero pointer
  assert_hit_needs_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> ($past(state_q) == ST_WALK && $past(ptr_q) != '0));
endmodule

// File: rtl/mac_hash_lookup.sv
module mac_hash_lookup
  import mac_hash_pkg::*;
#(
  parameter int KEY_W   = MAC_W,
  parameter int PORT_W  = EGRESS_W,
  parameter int BUCKETS = 16,
  parameter int ENTRIES = 32,
  localparam int BKT_W  = $clog2(BUCKETS),
  localparam int PTR_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [KEY_W-1:0]  req_key,
  output logic              res_valid,
  output logic              res_hit,
  output logic [PORT_W-1:0] res_port,
  input  logic              wr_en,
  output logic              wr_ack,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic [KEY_W-1:0]  wr_key,
  input  logic [PORT_W-1:0] wr_port
);
  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic [BKT_W-1:0]  req_bkt;
  logic [BKT_W-1:0]  wr_bkt;
  logic [PTR_W-1:0]  head_ptr;
  logic [PTR_W-1:0]  ent_ptr;
  logic              ent_valid;
  logic [KEY_W-1:0]  ent_key;
  logic [PORT_W-1:0] ent_port;
  logic [PTR_W-1:0]  ent_next;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  mac_crc16_hash #(.KEY_W(KEY_W), .BKT_W(BKT_W)) u_req_hash (
    .key    (req_key),
    .bucket (req_bkt)
  );

  mac_crc16_hash #(.KEY_W(KEY_W), .BKT_W(BKT_W)) u_wr_hash (
    .key    (wr_key),
    .bucket (wr_bkt)
  );

  mac_entry_store #(
    .KEY_W(KEY_W), .PORT_W(PORT_W), .BUCKETS(BUCKETS), .ENTRIES(ENTRIES)
  ) u_store (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .head_rd_bkt  (req_bkt),
    .head_rd_ptr  (head_ptr),
    .ent_rd_ptr   (ent_ptr),
    .ent_rd_valid (ent_valid),
    .ent_rd_key   (ent_key),
    .ent_rd_port  (ent_port),
    .ent_rd_next  (ent_next),
    .wr_strobe    (wr_ack),
    .wr_bkt       (wr_bkt),
    .wr_idx       (wr_idx),
    .wr_key       (wr_key),
    .wr_port      (wr_port)
  );

  mac_walk_ctrl #(.KEY_W(KEY_W), .PORT_W(PORT_W), .PTR_W(PTR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_key   (req_key),
    .head_ptr  (head_ptr),
    .ent_ptr   (ent_ptr),
    .ent_valid (ent_valid),
    .ent_key   (ent_key),
    .ent_port  (ent_port),
    .ent_next  (ent_next),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_port  (res_port),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_ack    (wr_ack)
  );
endmodule

// File: tb/mac_hash_lookup_tb.sv
module mac_hash_lookup_tb;
  localparam int KW = 48;
  localparam int PW = 4;
  localparam int NB = 16;
  localparam int NE = 32;
  localparam int BW = 4;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [KW-1:0] req_key = '0;
  logic          res_valid;
  logic          res_hit;
  logic [PW-1:0] res_port;
  logic          wr_en = 1'b0;
  logic          wr_ack;
  logic [IW-1:0] wr_idx = '0;
  logic [KW-1:0] wr_key = '0;
  logic [PW-1:0] wr_port = '0;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mac_hash_lookup u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_key(req_key),
    .res_valid(res_valid), .res_hit(res_hit), .res_port(res_port),
    .wr_en(wr_en), .wr_ack(wr_ack), .wr_idx(wr_idx), .wr_key(wr_key), .wr_port(wr_port)
  );

  // Reference model of the chains
  logic [IW-1:0] m_head [NB];
  logic [IW-1:0] m_next [NE];
  logic [KW-1:0] m_key  [NE];
  logic [PW-1:0] m_port [NE];

  function automatic logic [BW-1:0] ref_bucket(input logic [KW-1:0] k);
    logic [15:0] c = 16'h0;
    for (int i = KW - 1; i >= 0; i--) begin
      if (c[15] ^ k[i]) c = {c[14:0], 1'b0} ^ 16'h8005;
      else              c = {c[14:0], 1'b0};
    end
    return c[BW-1:0];
  endfunction

  task automatic model_clear();
    for (int b = 0; b < NB; b++) m_head[b] = '0;
  endtask

  task automatic model_write(input logic [IW-1:0] i, input logic [KW-1:0] k, input logic [PW-1:0] p);
    logic [BW-1:0] b = ref_bucket(k);
    m_next[i] = m_head[b];
    m_key[i]  = k;
    m_port[i] = p;
    m_head[b] = i;
  endtask

  task automatic model_lookup(input logic [KW-1:0] k, output bit h, output logic [PW-1:0] p, output int lat);
    logic [IW-1:0] q = m_head[ref_bucket(k)];
    h = 0; p = '0; lat = 0;
    for (int n = 0; n <= NE; n++) begin
      lat++;
      if (q == '0) break;
      if (m_key[q] == k) begin h = 1; p = m_port[q]; break; end
      q = m_next[q];
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_clear();
  endtask

  // Called just after the accepting edge's following low phase has not yet passed.
  task automatic wait_result(input bit eh, input logic [PW-1:0] ep, input int el, input string tag);
    int  lat = 0;
    bit  got = 0;
    for (int n = 0; n < 64 && !got; n++) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      req_valid = 1'b0;
      wr_en     = 1'b0;
      if (res_valid) got = 1;
    end
    check(got, {tag, " R7 result seen"}, got, 1);
    check(lat == el, {tag, " R6 latency"}, lat, el);
    check(res_hit == eh, {tag, " R4/R5 hit"}, res_hit, eh);
    check(res_port == ep, {tag, " R4/R5 port"}, res_port, ep);
    @(negedge clk);
    check(!res_valid && req_ready, {tag, " R7 strobe drops, ready back"}, {res_valid, req_ready}, 2'b01);
  endtask

  task automatic do_lookup(input logic [KW-1:0] k, input string tag);
    bit eh; logic [PW-1:0] ep; int el;
    model_lookup(k, eh, ep, el);
    @(negedge clk);
    req_valid = 1'b1; req_key = k;
    #1 check(req_ready, {tag, " R7 ready when idle"}, req_ready, 1);
    @(posedge clk);
    wait_result(eh, ep, el, tag);
  endtask

  task automatic do_write(input logic [IW-1:0] i, input logic [KW-1:0] k, input logic [PW-1:0] p,
                          input bit exp_ack, input string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = i; wr_key = k; wr_port = p;
    #1 check(wr_ack == exp_ack, {tag, " write ack"}, wr_ack, exp_ack);
    if (exp_ack) model_write(i, k, p);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Stimulus table: {is_write, idx[4:0], port[3:0], key[47:0]}
  localparam int NV = 14;
  localparam logic [57:0] VEC [NV] = '{
    {1'b1, 5'd1, 4'd3, 48'h00A0_C912_3401},
    {1'b1, 5'd2, 4'd7, 48'h00A0_C912_3402},
    {1'b1, 5'd3, 4'd1, 48'h0015_5D00_AB10},
    {1'b1, 5'd4, 4'd9, 48'h3C97_0E44_0001},
    {1'b1, 5'd5, 4'd12, 48'hF0DE_F1AA_BB02},
    {1'b1, 5'd6, 4'd15, 48'h0001_0203_0405},
    {1'b0, 5'd0, 4'd0, 48'h00A0_C912_3401},
    {1'b0, 5'd0, 4'd0, 48'h0015_5D00_AB10},
    {1'b0, 5'd0, 4'd0, 48'h0001_0203_0405},
    {1'b0, 5'd0, 4'd0, 48'hFFFF_FFFF_FFFF},
    {1'b1, 5'd7, 4'd4, 48'h5254_0012_3456},
    {1'b0, 5'd0, 4'd0, 48'h5254_0012_3456},
    {1'b0, 5'd0, 4'd0, 48'h3C97_0E44_0001},
    {1'b0, 5'd0, 4'd0, 48'h0000_0000_0000}
  };

  initial begin
    logic [KW-1:0] ck [4];
    logic [BW-1:0] tb;
    int            found;
    bit eh; logic [PW-1:0] ep; int el;

    model_clear();
    do_reset();

    // R2: reset state
    check(req_ready == 1'b1, "R2 ready after reset", req_ready, 1);
    check(res_valid == 1'b0, "R2 no result after reset", res_valid, 0);
    do_lookup(48'h00A0_C912_3401, "R2 empty table miss");

    // Table walk (R3, R4, R5, R6)
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][57]) do_write(VEC[v][56:52], VEC[v][47:0], VEC[v][51:48], 1'b1, "R3 table write");
      else            do_lookup(VEC[v][47:0], "R4 table lookup");
    end

    // R1 / R3 / R6: build a chain of colliding keys found with the reference hash
    do_reset();
    ck[0] = 48'h0200_0000_0001;
    tb = ref_bucket(ck[0]);
    found = 1;
    for (int c = 1; c < 4000 && found < 4; c++) begin
      if (ref_bucket(48'h0200_0000_0001 + 48'(c)) == tb) begin
        ck[found] = 48'h0200_0000_0001 + 48'(c);
        found++;
      end
    end
    check(found == 4, "R1 collision keys found", found, 4);
    do_write(5'd10, ck[0], 4'd2, 1'b1, "R1 chain write 1");
    do_write(5'd11, ck[1], 4'd5, 1'b1, "R1 chain write 2");
    do_write(5'd12, ck[2], 4'd8, 1'b1, "R1 chain write 3");
    do_lookup(ck[2], "R3 newest entry first");
    do_lookup(ck[1], "R6 middle entry");
    do_lookup(ck[0], "R1 oldest entry third");
    do_lookup(ck[3], "R5 miss after full chain");

    // R10: duplicate key, newest port wins
    do_write(5'd13, ck[0], 4'd9, 1'b1, "R10 duplicate write");
    do_lookup(ck[0], "R10 newest duplicate");

    // R8: write refused while a lookup walks
    model_lookup(ck[1], eh, ep, el);
    @(negedge clk);
    req_valid = 1'b1; req_key = ck[1];
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    wr_en = 1'b1; wr_idx = 5'd14; wr_key = 48'h7777_0000_1234; wr_port = 4'd6;
    #1 check(wr_ack == 1'b0, "R8 write refused while busy", wr_ack, 0);
    wait_result(eh, ep, el, "R8 lookup under write");
    do_lookup(48'h7777_0000_1234, "R8 refused write left no entry");

    // R9: index 0 refused
    do_write(5'd0, 48'h6666_0000_9999, 4'd3, 1'b0, "R9 null index");
    do_lookup(48'h6666_0000_9999, "R9 null write left no entry");

    // R11: lookup and write on the same edge
    model_lookup(48'h5555_0000_AAAA, eh, ep, el);
    @(negedge clk);
    req_valid = 1'b1; req_key = 48'h5555_0000_AAAA;
    wr_en = 1'b1; wr_idx = 5'd15; wr_key = 48'h5555_0000_AAAA; wr_port = 4'd11;
    #1 check(wr_ack == 1'b1, "R11 write taken when idle", wr_ack, 1);
    @(posedge clk);
    model_write(5'd15, 48'h5555_0000_AAAA, 4'd11);
    wait_result(eh, ep, el, "R11 lookup sees old table");
    do_lookup(48'h5555_0000_AAAA, "R11 later lookup sees write");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule